// File: doc/BRIEF.md
# Indexed Indirect Jump Sequencer

This block steps an 8-bit accumulator CPU through the jump whose target is fetched through an absolute address indexed by X (opcode 0x7C). It takes over once the opcode byte has been fetched. First it reads the two-byte absolute operand from the instruction stream. It adds X to the low byte with an 8-bit adder and keeps the carry in an internal flag. It applies that carry to the high byte in a cycle of its own. It then reads a two-byte target through the resulting pointer, fetches the opcode at the target into the instruction register and leaves the program counter one past the target.

The sequence always lasts six cycles, counting the opcode fetch that closes it. It has no fast path and no page-cross branch. Every program-counter increment is a full 16-bit add of one to the address currently on the bus, so no byte fetch ever waits on a carry. The memory port registers its address, and read data for that address is valid within the same cycle. The sequencer starts when `op_valid` is high in an idle cycle and `ir_in` carries the opcode. Any other opcode is left for other logic.

Top module: `jmpx_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `mem_rd` are low and `pc` and `ir` are zero.
- R2: An `op_valid` with an `ir_in` value other than 0x7C causes no step: `busy` stays low and `pc` and `ir` keep their values.
- R3: Accepting 0x7C with `pc_in` = P starts the sequence on the next cycle. Step 1 reads the operand low byte at P. Step 2 reads the operand high byte at P+1 (a 16-bit increment).
- R4: Step 3 performs no memory read (`mem_rd` low); it adds the latched carry into the pointer high byte.
- R5: Step 4 reads at the pointer, which is the 16-bit operand plus the zero-extended X sampled in step 2, modulo 2^16.
- R6: Step 5 reads at pointer+1, a full 16-bit increment (pointer low byte 0xFF moves to the next page).
- R7: Step 6 reads at the target {byte from step 5, byte from step 4}. `done` is high in that cycle only, exactly six cycles after acceptance, whether or not the X addition crosses a page.
- R8: After step 6, `ir` holds the byte read at the target and `pc` equals target+1 modulo 2^16.
- R9: An `op_valid` pulse while `busy` is high is ignored: the bus trace and final `pc`/`ir` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode fetched; `ir_in` and `pc_in` are valid |
| ir_in | input | 8 | Opcode just fetched |
| pc_in | input | 16 | Address of the byte following the opcode |
| x_reg | input | 8 | Index register value, sampled in step 2 |
| mem_addr | output | 16 | Read address, driven from registers |
| mem_rd | output | 1 | Read strobe for the current cycle |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| pc | output | 16 | Program counter |
| ir | output | 8 | Instruction register |
| busy | output | 1 | Sequence in steps 1 to 6 |
| done | output | 1 | High in step 6, the next-opcode fetch |

## Verification
Once an opcode is accepted at a clock edge, the bus values of step k can be seen during the k-th cycle after that edge. `done` appears in the sixth cycle, and `pc` and `ir` take their final values one edge later. The driver queues the six expected step records before it raises `op_valid`. The monitor pops one record at each falling edge while `busy` is high, so a step that comes early, late or is missing shows up as a mismatch or as a non-empty queue. The final `pc`/`ir` check samples at the seventh falling edge after the stimulus.

// File: rtl/jmpx_pkg.sv
// Package: shared step encoding for the indexed indirect jump sequencer.
// Assumes one step per clock; ST_IDLE means no sequence in flight.
package jmpx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPLO  = 3'd1,
        ST_OPHI  = 3'd2,
        ST_PTRHI = 3'd3,
        ST_TGTLO = 3'd4,
        ST_TGTHI = 3'd5,
        ST_FETCH = 3'd6
    } step_e;
endpackage

// File: rtl/jmpx_byte_add.sv
// Module: byte-wide adder with carry in and carry out.
// Assumes unsigned operands; purely combinational.
module jmpx_byte_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Single ripple-free add; carry out taken from the extra bit.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/jmpx_addr_inc.sv
// Module: full-width single-cycle incrementer for bus addresses.
// Assumes wrap modulo 2^W; purely combinational.
module jmpx_addr_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr_in,
    output logic [W-1:0] addr_out
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    // Add one across the whole word in one cycle.
    always_comb begin
        addr_out = addr_in + ONE;
    end
endmodule

// File: rtl/jmpx_ctrl.sv
// Module: fixed six-step controller for the indexed indirect jump.
// Assumes op_match is already decoded; no branch depends on data.
module jmpx_ctrl
    import jmpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  op_valid,
    input  logic  op_match,
    output step_e step,
    output logic  accept,
    output logic  busy,
    output logic  done
);
    // Decode status from the current step.
    always_comb begin
        busy   = (step != ST_IDLE);
        done   = (step == ST_FETCH);
        accept = (step == ST_IDLE) && op_valid && op_match;
    end

    // Advance one step per cycle; idle waits for a matching opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_IDLE;
        end else begin
            unique case (step)
                ST_IDLE:  step <= accept ? ST_OPLO : ST_IDLE;
                ST_OPLO:  step <= ST_OPHI;
                ST_OPHI:  step <= ST_PTRHI;
                ST_PTRHI: step <= ST_TGTLO;
                ST_TGTLO: step <= ST_TGTHI;
                ST_TGTHI: step <= ST_FETCH;
                ST_FETCH: step <= ST_IDLE;
                default:  step <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jmpx_datapath.sv
// Module: registers, bus address mux and arithmetic for the jump.
// Assumes read data is valid in the same cycle as the registered address.
module jmpx_datapath
    import jmpx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_e                 step,
    input  logic                  accept,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     ir_in,
    input  logic [DATA_W-1:0]     x_reg,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_rd,
    output logic [2*DATA_W-1:0]   pc,
    output logic [DATA_W-1:0]     ir
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] hold_b;
    logic              int_carry;
    logic [DATA_W-1:0] dp_lo;
    logic [DATA_W-1:0] dp_hi;
    logic [ADDR_W-1:0] bus_next;
    logic [DATA_W-1:0] add_rhs;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;

    // Bus address: data pointer in the final fetch, otherwise PC.
    always_comb begin
        mem_addr = (step == ST_FETCH) ? {dp_hi, dp_lo} : pc;
        mem_rd   = step inside {ST_OPLO, ST_OPHI, ST_TGTLO, ST_TGTHI, ST_FETCH};
    end

    // Adder operand select: X in step 2, latched carry in step 3.
    always_comb begin
        add_rhs = (step == ST_OPHI) ? x_reg : '0;
        add_cin = (step == ST_PTRHI) ? int_carry : 1'b0;
    end

    jmpx_byte_add #(.W(DATA_W)) u_add (
        .a    (hold_b),
        .b    (add_rhs),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    jmpx_addr_inc #(.W(ADDR_W)) u_inc (
        .addr_in  (mem_addr),
        .addr_out (bus_next)
    );

    // Program counter: load, bus increment, or byte-wise pointer build.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (accept) begin
            pc <= pc_in;
        end else begin
            unique case (step)
                ST_OPLO, ST_TGTLO, ST_FETCH: pc <= bus_next;
                ST_OPHI:  pc <= {pc[ADDR_W-1:DATA_W], add_sum};
                ST_PTRHI: pc <= {add_sum, pc[DATA_W-1:0]};
                default:  pc <= pc;
            endcase
        end
    end

    // Instruction register: opcode on accept, next opcode in step 6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
        end else if (accept) begin
            ir <= ir_in;
        end else if (step == ST_FETCH) begin
            ir <= mem_rdata;
        end
    end

    // Holding byte and internal carry for the operand add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_b    <= '0;
            int_carry <= 1'b0;
        end else begin
            if (step == ST_OPLO || step == ST_OPHI) hold_b <= mem_rdata;
            if (step == ST_OPHI) int_carry <= add_cout;
        end
    end

    // Data pointer bytes captured from the pointer reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_lo <= '0;
            dp_hi <= '0;
        end else begin
            if (step == ST_TGTLO) dp_lo <= mem_rdata;
            if (step == ST_TGTHI) dp_hi <= mem_rdata;
        end
    end
endmodule

// File: rtl/jmpx_seq.sv
// Module: top of the indexed indirect jump sequencer.
// Assumes the opcode has been fetched when op_valid is high; other
// opcodes, interrupts and writes are handled elsewhere.
module jmpx_seq #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] OPCODE = 8'h7C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [DATA_W-1:0]   ir_in,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   x_reg,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                mem_rd,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] pc,
    output logic [DATA_W-1:0]   ir,
    output logic                busy,
    output logic                done
);
    import jmpx_pkg::*;

    step_e step;
    logic  accept;
    logic  op_match;

    // Opcode decode for the trigger.
    always_comb begin
        op_match = (ir_in == OPCODE);
    end

    jmpx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_match (op_match),
        .step     (step),
        .accept   (accept),
        .busy     (busy),
        .done     (done)
    );

    jmpx_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .accept    (accept),
        .pc_in     (pc_in),
        .ir_in     (ir_in),
        .x_reg     (x_reg),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .pc        (pc),
        .ir        (ir)
    );
endmodule

// File: rtl/jmpx_seq_chk.sv
// Module: port-level checker for jmpx_seq, bound into every instance.
// Assumes the step counter below tracks cycles since busy rose.
module jmpx_seq_chk #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] OPCODE = 8'h7C
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [DATA_W-1:0]   ir_in,
    input logic [2*DATA_W-1:0] pc_in,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic                mem_rd,
    input logic [DATA_W-1:0]   mem_rdata,
    input logic [2*DATA_W-1:0] pc,
    input logic [DATA_W-1:0]   ir,
    input logic                busy,
    input logic                done
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [2:0] busy_cnt;

    // Count cycles spent busy; zero in the first busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 3'd1;
        else            busy_cnt <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_rd && pc == '0 && ir == '0));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && ir_in != OPCODE) |=> (!busy && $stable(pc) && $stable(ir)));

    assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && ir_in == OPCODE) |=> (busy && mem_rd && mem_addr == $past(pc_in)));

    assert_operand_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == 3'd0) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == 3'd2) |-> !mem_rd);

    assert_ptr_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == 3'd3) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_done_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && busy_cnt == 3'd5 && mem_rd));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_final_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pc == ADDR_W'($past(mem_addr) + 1'b1) && ir == $past(mem_rdata)));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt < 3'd5) |=> busy);
endmodule

bind jmpx_seq jmpx_seq_chk #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .ir_in     (ir_in),
    .pc_in     (pc_in),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ir        (ir),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_jmpx_seq.sv
module tb_jmpx_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          stepno;
        bit          chk_addr;
        logic [15:0] addr;
        logic        rd;
        logic        dn;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  ir_in = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  x_reg = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] pc;
    logic [7:0]  ir;
    logic        busy;
    logic        done;

    int tests = 0;
    int fails = 0;
    exp_t exp_q[$];
    logic [7:0] mem_img [logic [15:0]];

    jmpx_seq dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ir_in(ir_in),
        .pc_in(pc_in), .x_reg(x_reg), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .pc(pc), .ir(ir), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_read(input logic [15:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Memory model: data for the registered address, updated away from the edge.
    always @(negedge clk) mem_rdata = mem_read(mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(input int s);
        case (s)
            1, 2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Monitor: pop one expected step per busy cycle and compare.
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected busy step", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk_addr)
                    check(mem_addr == e.addr, req_of(e.stepno), "bus address", mem_addr, e.addr);
                check(mem_rd == e.rd, req_of(e.stepno), "read strobe", mem_rd, e.rd);
                check(done == e.dn, "R7", "done flag", done, e.dn);
            end
        end
    end

    // Driver: load memory, queue the six expected steps, fire the opcode.
    task automatic run_jump(input logic [15:0] p0, input logic [7:0] xv,
                            input logic [15:0] opnd, input logic [15:0] tgt,
                            input logic [7:0] nxt, input bit disturb);
        logic [15:0] ptr;
        ptr = opnd + {8'h00, xv};
        mem_img[p0] = opnd[7:0];
        mem_img[p0 + 16'd1] = opnd[15:8];
        mem_img[ptr] = tgt[7:0];
        mem_img[ptr + 16'd1] = tgt[15:8];
        mem_img[tgt] = nxt;
        exp_q.push_back('{1, 1'b1, p0, 1'b1, 1'b0});
        exp_q.push_back('{2, 1'b1, p0 + 16'd1, 1'b1, 1'b0});
        exp_q.push_back('{3, 1'b0, 16'h0000, 1'b0, 1'b0});
        exp_q.push_back('{4, 1'b1, ptr, 1'b1, 1'b0});
        exp_q.push_back('{5, 1'b1, ptr + 16'd1, 1'b1, 1'b0});
        exp_q.push_back('{6, 1'b1, tgt, 1'b1, 1'b1});
        @(negedge clk);
        x_reg = xv; pc_in = p0; ir_in = 8'h7C; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (disturb) begin
            @(negedge clk);
            // R9: second trigger mid-sequence must be ignored
            pc_in = 16'hBEEF; ir_in = 8'h7C; op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            repeat (6) @(negedge clk);
        end
        check(exp_q.size() == 0, "R7", "steps left in queue", exp_q.size(), 0);
        check(!busy, "R7", "busy after six steps", busy, 0);
        check(pc == tgt + 16'd1, "R8", "final pc", pc, tgt + 16'd1);
        check(ir == nxt, "R8", "final ir", ir, nxt);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] pc_keep;
        logic [7:0]  ir_keep;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy, "R1", "busy in reset", busy, 0);
        check(!done, "R1", "done in reset", done, 0);
        check(!mem_rd, "R1", "mem_rd in reset", mem_rd, 0);
        check(pc == 16'h0000, "R1", "pc in reset", pc, 0);
        check(ir == 8'h00, "R1", "ir in reset", ir, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && pc == 16'h0000, "R1", "idle after reset", busy, 0);

        // R5: no page cross on the X add
        run_jump(16'h0200, 8'h05, 16'h3010, 16'h7A00, 8'hE8, 1'b0);
        // R7: page cross on the X add keeps six steps
        run_jump(16'h0400, 8'h20, 16'h30F0, 16'h6123, 8'hC8, 1'b0);
        // R6: pointer low byte 0xFF
        run_jump(16'h0600, 8'h05, 16'h40FA, 16'h5555, 8'h18, 1'b0);
        // R3: operand straddles a page boundary
        run_jump(16'h12FF, 8'h00, 16'h2222, 16'h0900, 8'h38, 1'b0);
        // R5/R8: pointer wraps past 0xFFFF, target 0xFFFF wraps pc to 0
        run_jump(16'h0800, 8'h20, 16'hFFF0, 16'hFFFF, 8'h4C, 1'b0);
        // R9: trigger while busy is ignored
        run_jump(16'h0A00, 8'h81, 16'h1290, 16'h3456, 8'hAA, 1'b1);

        // R2: foreign opcode ignored
        pc_keep = pc; ir_keep = ir;
        @(negedge clk);
        pc_in = 16'h5555; ir_in = 8'hEA; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(!busy, "R2", "busy after foreign opcode", busy, 0);
        repeat (3) @(negedge clk);
        check(!busy && !mem_rd, "R2", "still idle", busy, 0);
        check(pc == pc_keep, "R2", "pc unchanged", pc, pc_keep);
        check(ir == ir_keep, "R2", "ir unchanged", ir, ir_keep);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule